// File: doc/BRIEF.md
# Paged MMU Control Register File

This block stores the programmable state of a paged memory management unit: two 64-bit root pointers (one for user-mode tables, one for supervisor-mode tables), a translation control word, two transparent-window words and a seven-bit fault status register. Software reaches every register through a small synchronous register bus. Read data is combinational from the current bus address. The block also drives the translation-enable bit and the two window-enable bits to the translation datapath.

Any load of a register that shapes the address mapping may make cached translations stale. Each bus write therefore carries a flush-inhibit qualifier. When the qualifier is low on a mapping write, the block sends a one-clock flush request to the external translation cache. Reset switches translation off but never requests a flush, so software must flush explicitly after reset if the cache contents are no longer trusted. The status register is normally loaded by a test engine through a strobe-qualified result port, and fault handlers read it back.

Top module: `mmu_ctl_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared to zero, so `xlat_en` and `win_en` become 0. `flush_req` stays 0 during reset and in the first cycle after reset, even if a write is presented during reset.
- R2: A write to address 1, 3, 4, 5 or 6 with `bus_nofl`=0 raises `flush_req` for exactly the one cycle after the accepting edge.
- R3: A write to address 1, 3, 4, 5 or 6 with `bus_nofl`=1 updates the register and raises no flush request.
- R4: Each root pointer is written as two 32-bit halves: user pointer low/high at addresses 0/1 and supervisor pointer low/high at addresses 2/3. A write to a low half (address 0 or 2) never flushes.
- R5: A software write to the status register (address 7) never raises `flush_req`, whatever `bus_nofl` is.
- R6: When `test_vld` is 1 at an edge, the status register loads `test_res`. If a software status write happens in the same cycle, the strobe wins.
- R7: `bus_rdata` returns the addressed register. Address 4 is translation control, addresses 5 and 6 are windows 0 and 1, and address 7 returns the status in bits 6:0 with zeros above.
- R8: `xlat_en` equals bit 31 of the translation control word. `win_en[i]` equals bit 15 of window word i.
- R9: A write is accepted only when `bus_sel` and `bus_we` are both 1. Otherwise no register changes and no flush request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_we | input | 1 | Write enable (with bus_sel) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_nofl | input | 1 | Flush-inhibit qualifier for this write |
| bus_rdata | output | 32 | Read data for bus_addr |
| test_vld | input | 1 | Test-result strobe |
| test_res | input | 7 | Test-result status bits |
| flush_req | output | 1 | One-cycle translation cache flush request |
| xlat_en | output | 1 | Translation enable |
| win_en | output | 2 | Transparent window enables |

## Verification
Two events can land on the status register in the same cycle: a software store to address 7 and a test-result strobe. The bench forces this collision with several distinct data and result patterns and expects the read-back to hold the strobe value. A second overlap is reset with a pending flush-qualified write. The bench presents a mapping write while reset is held and judges that `flush_req` stays low and that the enables come out cleared.

// File: rtl/mmu_ctl_pkg.sv
// Shared definitions for the MMU control register file.
// Assumes a 3-bit word address space with one register word per address.
package mmu_ctl_pkg;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 3;
    localparam int unsigned ST_W   = 7;
    localparam int unsigned N_WIN  = 2;
    localparam int unsigned N_ROOT = 2;

    typedef enum logic [AW-1:0] {
        A_UROOT_LO = 3'd0,
        A_UROOT_HI = 3'd1,
        A_SROOT_LO = 3'd2,
        A_SROOT_HI = 3'd3,
        A_XCTL     = 3'd4,
        A_WIN0     = 3'd5,
        A_WIN1     = 3'd6,
        A_STAT     = 3'd7
    } reg_addr_e;

    // True for addresses whose write may change the mapping and so may flush
    function automatic logic flush_eligible(input logic [AW-1:0] a);
        return (a == A_UROOT_HI) || (a == A_SROOT_HI) || (a == A_XCTL) ||
               (a == A_WIN0) || (a == A_WIN1);
    endfunction
endpackage

// File: rtl/mmu_root_ptr.sv
// 64-bit root pointer held as two independently written halves.
// Assumes at most one half strobe per cycle; reset clears both halves.
module mmu_root_ptr #(
    parameter int unsigned HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [HW-1:0] wdata,
    output logic [HW-1:0] q_lo,
    output logic [HW-1:0] q_hi
);
    // Low half storage
    always_ff @(posedge clk) begin
        if (!rst_n)     q_lo <= '0;
        else if (we_lo) q_lo <= wdata;
    end

    // High half storage
    always_ff @(posedge clk) begin
        if (!rst_n)     q_hi <= '0;
        else if (we_hi) q_hi <= wdata;
    end
endmodule

// File: rtl/mmu_ctl_word.sv
// Control word with one enable bit exported to the datapath.
// Assumes EN_BIT < W; reset clears the whole word, the enable included.
module mmu_ctl_word #(
    parameter int unsigned W      = 32,
    parameter int unsigned EN_BIT = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic         en
);
    // Word storage
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    // Enable tap
    assign en = q[EN_BIT];
endmodule

// File: rtl/mmu_flush_gen.sv
// Produces a one-cycle flush request after a qualifying accepted write.
// Assumes at most one write per cycle; reset forces the request low.
module mmu_flush_gen
    import mmu_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic [AW-1:0] addr,
    input  logic          nofl,
    output logic          flush_req
);
    logic want;

    // Qualify the write: a mapping register, with flush not inhibited
    assign want = wr_acc && flush_eligible(addr) && !nofl;

    // Register the request so it appears in the cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) flush_req <= 1'b0;
        else        flush_req <= want;
    end
endmodule

// File: rtl/mmu_status_reg.sv
// Fault status bits, loaded by the test engine or by software.
// Assumes the test strobe has priority over a software write in the same cycle.
module mmu_status_reg #(
    parameter int unsigned SW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [SW-1:0] sw_data,
    input  logic          tst_vld,
    input  logic [SW-1:0] tst_data,
    output logic [SW-1:0] q
);
    // Status storage, strobe first
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (tst_vld) q <= tst_data;
        else if (sw_we)   q <= sw_data;
    end
endmodule

// File: rtl/mmu_ctl_regs.sv
// Top of the MMU control register file: decode, storage instances,
// flush generation and read multiplexer.
// Assumes a single-master register bus with one access per cycle.
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned XCTL_EN_BIT = 31,
    parameter int unsigned WIN_EN_BIT  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_nofl,
    output logic [DW-1:0]    bus_rdata,
    input  logic             test_vld,
    input  logic [ST_W-1:0]  test_res,
    output logic             flush_req,
    output logic             xlat_en,
    output logic [N_WIN-1:0] win_en
);
    logic                   wr_acc;
    logic [DW-1:0]          root_lo [N_ROOT];
    logic [DW-1:0]          root_hi [N_ROOT];
    logic [DW-1:0]          xctl_q;
    logic [DW-1:0]          win_q   [N_WIN];
    logic [ST_W-1:0]        st_q;

    // Write acceptance
    assign wr_acc = bus_sel && bus_we;

    // Root pointers: pointer r occupies addresses 2r (low) and 2r+1 (high)
    for (genvar r = 0; r < N_ROOT; r++) begin : g_root
        localparam logic [AW-1:0] LO_A = AW'(2 * r);
        localparam logic [AW-1:0] HI_A = AW'(2 * r + 1);
        mmu_root_ptr #(.HW(DW)) u_root (
            .clk   (clk),
            .rst_n (rst_n),
            .we_lo (wr_acc && bus_addr == LO_A),
            .we_hi (wr_acc && bus_addr == HI_A),
            .wdata (bus_wdata),
            .q_lo  (root_lo[r]),
            .q_hi  (root_hi[r])
        );
    end

    // Translation control word
    mmu_ctl_word #(.W(DW), .EN_BIT(XCTL_EN_BIT)) u_xctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_acc && bus_addr == A_XCTL),
        .wdata (bus_wdata),
        .q     (xctl_q),
        .en    (xlat_en)
    );

    // Transparent windows at consecutive addresses from A_WIN0
    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        localparam logic [AW-1:0] WA = AW'(int'(A_WIN0) + w);
        mmu_ctl_word #(.W(DW), .EN_BIT(WIN_EN_BIT)) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_acc && bus_addr == WA),
            .wdata (bus_wdata),
            .q     (win_q[w]),
            .en    (win_en[w])
        );
    end

    // Fault status
    mmu_status_reg #(.SW(ST_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (wr_acc && bus_addr == A_STAT),
        .sw_data  (bus_wdata[ST_W-1:0]),
        .tst_vld  (test_vld),
        .tst_data (test_res),
        .q        (st_q)
    );

    // Flush request generation
    mmu_flush_gen u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_acc),
        .addr      (bus_addr),
        .nofl      (bus_nofl),
        .flush_req (flush_req)
    );

    // Read multiplexer
    always_comb begin
        unique case (bus_addr)
            A_UROOT_LO: bus_rdata = root_lo[0];
            A_UROOT_HI: bus_rdata = root_hi[0];
            A_SROOT_LO: bus_rdata = root_lo[1];
            A_SROOT_HI: bus_rdata = root_hi[1];
            A_XCTL:     bus_rdata = xctl_q;
            A_WIN0:     bus_rdata = win_q[0];
            A_WIN1:     bus_rdata = win_q[1];
            default:    bus_rdata = {{(DW-ST_W){1'b0}}, st_q};
        endcase
    end
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
// Temporal checks for mmu_ctl_regs, bound to every instance of the top.
module mmu_ctl_regs_chk
    import mmu_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic             bus_nofl,
    input logic             test_vld,
    input logic [ST_W-1:0]  test_res,
    input logic             flush_req,
    input logic             xlat_en,
    input logic [N_WIN-1:0] win_en,
    input logic [ST_W-1:0]  st_q
);
    logic wr;
    logic map_a;
    assign wr    = bus_sel && bus_we;
    assign map_a = (bus_addr == 3'd1) || (bus_addr == 3'd3) || (bus_addr == 3'd4) ||
                   (bus_addr == 3'd5) || (bus_addr == 3'd6);

    // R1: reset clears enables and holds the flush request low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!flush_req && !xlat_en && win_en == '0));

    // R2: qualifying mapping write flushes next cycle
    a_r2_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && map_a && !bus_nofl) |=> flush_req);

    // R3: inhibited writes never flush
    a_r3_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_nofl) |=> !flush_req);

    // R4: low-half root writes never flush
    a_r4_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (bus_addr == 3'd0 || bus_addr == 3'd2)) |=> !flush_req);

    // R5: status writes never flush
    a_r5_status_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 3'd7) |=> !flush_req);

    // R6: strobe value lands in status
    a_r6_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        test_vld |=> (st_q == $past(test_res)));

    // R8: control enable follows written bit 31
    a_r8_xlat_en: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 3'd4) |=> (xlat_en == $past(bus_wdata[31])));

    // R9: no accepted write, no flush
    a_r9_idle_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> !flush_req);
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_nofl  (bus_nofl),
    .test_vld  (test_vld),
    .test_res  (test_res),
    .flush_req (flush_req),
    .xlat_en   (xlat_en),
    .win_en    (win_en),
    .st_q      (st_q)
);

// File: tb/mmu_ctl_regs_tb_top.sv
// Self-checking bench: sweeps every address with both flush-inhibit values,
// several data patterns, status collisions and reset during activity.
module mmu_ctl_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we, bus_nofl, test_vld;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [6:0]  test_res;
    logic        flush_req, xlat_en;
    logic [1:0]  win_en;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_nofl(bus_nofl),
        .bus_rdata(bus_rdata), .test_vld(test_vld), .test_res(test_res),
        .flush_req(flush_req), .xlat_en(xlat_en), .win_en(win_en)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic map_addr(input int a);
        return a == 1 || a == 3 || a == 4 || a == 5 || a == 6;
    endfunction

    // Check every register and the enable outputs against the model
    task automatic check_all(input string req);
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a);
            #1;
            chk(req, bus_rdata, model[a]);
        end
        chk({req, "/R8 xlat_en"}, {31'b0, xlat_en}, {31'b0, model[4][31]});
        chk({req, "/R8 win_en"}, {30'b0, win_en}, {30'b0, model[6][15], model[5][15]});
    endtask

    // One bus write; checks the flush pulse and its end
    task automatic wr(input int a, input logic [31:0] d, input logic nf, input logic sel, input logic we);
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = 3'(a); bus_wdata = d; bus_nofl = nf;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (sel && we) model[a] = (a == 7) ? {25'b0, d[6:0]} : d;
        chk((sel && we) ? (nf ? "R3/R4/R5 flush" : "R2/R4/R5 flush") : "R9 flush",
            {31'b0, flush_req}, {31'b0, sel && we && !nf && map_addr(a)});
        @(negedge clk);
        chk("R2 single pulse", {31'b0, flush_req}, 32'b0);
    endtask

    task automatic do_reset(input logic with_write);
        @(negedge clk);
        rst_n = 1'b0;
        if (with_write) begin
            bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd4;
            bus_wdata = 32'hFFFF_FFFF; bus_nofl = 1'b0;
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 flush in reset", {31'b0, flush_req}, 32'b0);
        end
        bus_sel = 1'b0; bus_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flush after reset", {31'b0, flush_req}, 32'b0);
        for (int a = 0; a < 8; a++) model[a] = '0;
        check_all("R1/R7 reset");
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        bus_nofl = 0; test_vld = 0; test_res = 0;
        for (int a = 0; a < 8; a++) model[a] = '0;
        do_reset(1'b1);

        // Address x inhibit x pattern sweep
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 8; a++) begin
                for (int nf = 0; nf < 2; nf++) begin
                    logic [31:0] d;
                    d = (32'h9E37_79B9 * (p * 16 + a * 2 + nf + 1)) ^ (p[0] ? 32'h8000_8000 : 32'h0);
                    wr(a, d, nf[0], 1'b1, 1'b1);
                    check_all("R7 readback");
                end
            end
        end

        // R9: select without write, write without select
        for (int a = 0; a < 8; a++) begin
            wr(a, 32'h1234_5678 + 32'(a), 1'b0, 1'b1, 1'b0);
            wr(a, 32'hCAFE_0000 + 32'(a), 1'b0, 1'b0, 1'b1);
            check_all("R9 ignored");
        end

        // R6: strobe alone and strobe colliding with a status write
        for (int v = 0; v < 128; v += 9) begin
            @(negedge clk);
            test_vld = 1'b1; test_res = 7'(v);
            bus_sel = v[0]; bus_we = 1'b1; bus_addr = 3'd7;
            bus_wdata = ~32'(v); bus_nofl = 1'b0;
            @(negedge clk);
            test_vld = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
            chk("R5 status collision no flush", {31'b0, flush_req}, 32'b0);
            model[7] = {25'b0, 7'(v)};
            bus_addr = 3'd7; #1;
            chk("R6 strobe wins", bus_rdata, model[7]);
        end

        // Enables on, then reset mid-run with a pending qualifying write
        wr(4, 32'h8000_0001, 1'b1, 1'b1, 1'b1);
        wr(5, 32'h0000_8000, 1'b1, 1'b1, 1'b1);
        wr(6, 32'h0000_8000, 1'b1, 1'b1, 1'b1);
        check_all("R8 enables set");
        do_reset(1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule